// File: doc/BRIEF.md
# Dual Down-Counting Timer with Keyed Watchdog

This block contains two independent down-counting timers and a watchdog, all reached through a small word-addressed register bus. Each timer has its own mode register, count register and reload register. When a running timer reaches its terminal count it raises a flag in its mode register and a sticky bit in a shared status register. That status bit drives the timer's interrupt output. The timer then either reloads and keeps going or stops.

Each timer can be clocked by the core clock directly or through a prescaler of 4, 8 or 16. The watchdog stays idle until software writes two fixed key values to its control register, one directly after the other. Once armed, it counts down a fixed timeout and pulses a reset request for one clock each time the timeout expires. Only the block's own reset can disarm it.

Top module: `dual_timer_wdog`

## Requirements
- R1: After reset every readable register reads zero, both timer interrupt outputs are low and the watchdog reset output is low.
- R2: Registers use word addresses. Timer n occupies addresses 3n (mode), 3n+1 (count) and 3n+2 (reload). Address 6 is the shared status register and address 7 is the watchdog control register. In a mode register, bit 0 is the terminal-count flag, bit 1 is enable, bit 2 is reload, bits 5:4 are the prescale select and all other bits read as zero.
- R3: With prescale select 0 and a count value N written, an enabled timer decrements once per clock and hits terminal count N clocks after the clock edge that writes the enable. A disabled timer holds its count.
- R4: Prescale select 1, 2 and 3 divide the decrement rate by 4, 8 and 16, so terminal count comes N×4, N×8 or N×16 clocks after enable.
- R5: On terminal count with reload clear, the timer sets mode bit 0, clears its enable bit, leaves its count at zero and sets its status bit.
- R6: On terminal count with reload set, the timer loads its reload value into the count, stays enabled, and fires again after that many further decrements.
- R7: Status bit 0 belongs to timer 0 and bit 1 to timer 1. Each bit stays set until software writes 1 to it, and writing 0 leaves it unchanged. Each interrupt output equals its timer's status bit. Writing 1 to mode bit 0 clears the terminal-count flag.
- R8: The watchdog arms only when 0x1E1E1E1E is written to its control register and the next write to that register is 0xE1E1E1E1. Any other value written in between returns the sequence to its start. Bit 0 of the control register reads 1 while the watchdog is armed.
- R9: Once armed, the watchdog drives its reset output high for exactly one clock, WDOG_TIMEOUT clocks after the arming write, and again every WDOG_TIMEOUT clocks after that.
- R10: Once the watchdog is armed, no bus write disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrEn | input | 1 | Write strobe for one clock |
| busAddr | input | 3 | Word address for both read and write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| tmrIrq | output | 2 | Per-timer interrupt, bit n for timer n |
| wdogRst | output | 1 | One-clock watchdog reset request |

## Verification
A write lands on the clock edge that follows the cycle in which it is driven. Register reads are combinational, so a read value is due in the same cycle that the address is presented. A timer's terminal event, status bit and interrupt are due N×divisor clocks after the enabling write. The watchdog pulse is due WDOG_TIMEOUT clocks after the second key write and lasts one clock. The driver computes each due cycle from the cycle counter at the moment of the write and queues the expected value with that cycle number. The monitor compares a queued item only in the cycle it is due, sampling shortly after the falling edge. This way both the cycle just before an event and the event cycle itself are checked.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 3;
  localparam int TMR_NUM     = 2;
  localparam int REG_PER_TMR = 3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(TMR_NUM * REG_PER_TMR);
  localparam logic [ADDR_W-1:0] ADDR_WDOG   = ADDR_W'(TMR_NUM * REG_PER_TMR + 1);

  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h1E1E_1E1E;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'hE1E1_E1E1;

  localparam int MODE_TC  = 0;
  localparam int MODE_EN  = 1;
  localparam int MODE_RL  = 2;
  localparam int MODE_SEL = 4;

  localparam int PSC_W = 4;

  typedef enum logic [1:0] {
    UNLK_IDLE = 2'd0,
    UNLK_HALF = 2'd1,
    UNLK_DONE = 2'd2
  } unlock_state_t;

  typedef struct packed {
    logic [TMR_NUM-1:0] wrMode;
    logic [TMR_NUM-1:0] wrCount;
    logic [TMR_NUM-1:0] wrReload;
    logic               wrStatus;
    logic               wdogArm;
  } tmr_strobe_t;

  function automatic logic [PSC_W-1:0] divMinus1(input logic [1:0] sel);
    case (sel)
      2'd0:    divMinus1 = PSC_W'(0);
      2'd1:    divMinus1 = PSC_W'(3);
      2'd2:    divMinus1 = PSC_W'(7);
      default: divMinus1 = PSC_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output tmr_strobe_t       strobe
);

  unlock_state_t unlockState;
  logic          wdogWrite;

  assign wdogWrite = busWrEn && (busAddr == ADDR_WDOG);

  // Address decode into per-register write strobes
  always_comb begin
    strobe = '0;
    for (int i = 0; i < TMR_NUM; i++) begin
      strobe.wrMode[i]   = busWrEn && (busAddr == ADDR_W'(i * REG_PER_TMR));
      strobe.wrCount[i]  = busWrEn && (busAddr == ADDR_W'(i * REG_PER_TMR + 1));
      strobe.wrReload[i] = busWrEn && (busAddr == ADDR_W'(i * REG_PER_TMR + 2));
    end
    strobe.wrStatus = busWrEn && (busAddr == ADDR_STATUS);
    strobe.wdogArm  = wdogWrite && (unlockState == UNLK_HALF) && (busWdata == KEY_SECOND);
  end

  // Two-write key sequence; any wrong value restarts it
  always_ff @(posedge clk) begin
    if (rst) begin
      unlockState <= UNLK_IDLE;
    end else if (wdogWrite && unlockState != UNLK_DONE) begin
      if (busWdata == KEY_FIRST)
        unlockState <= UNLK_HALF;
      else if (unlockState == UNLK_HALF && busWdata == KEY_SECOND)
        unlockState <= UNLK_DONE;
      else
        unlockState <= UNLK_IDLE;
    end
  end

  assert_decode_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wrMode, strobe.wrCount, strobe.wrReload, strobe.wrStatus}));

  assert_arm_needs_first_key_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.wdogArm |-> (unlockState == UNLK_HALF));

  assert_done_is_final_R10: assert property (@(posedge clk) disable iff (rst)
    (unlockState == UNLK_DONE) |=> (unlockState == UNLK_DONE));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrMode,
  input  logic              wrCount,
  input  logic              wrReload,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] modeRd,
  output logic [CNT_W-1:0]  countRd,
  output logic [CNT_W-1:0]  reloadRd,
  output logic              hitPulse
);

  logic             enBit;
  logic             rlBit;
  logic             tcBit;
  logic [1:0]       selBits;
  logic [PSC_W-1:0] pscCnt;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reloadVal;
  logic             tick;

  assign tick     = enBit && (pscCnt == divMinus1(selBits));
  assign hitPulse = tick && (count <= CNT_W'(1));

  // Prescaler restarts on every mode write and while stopped
  always_ff @(posedge clk) begin
    if (rst)
      pscCnt <= '0;
    else if (wrMode || !enBit || tick)
      pscCnt <= '0;
    else
      pscCnt <= pscCnt + PSC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      reloadVal <= '0;
    end else begin
      if (wrReload)
        reloadVal <= wdata[CNT_W-1:0];
      if (wrCount)
        count <= wdata[CNT_W-1:0];
      else if (hitPulse)
        count <= rlBit ? reloadVal : '0;
      else if (tick)
        count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enBit   <= 1'b0;
      rlBit   <= 1'b0;
      selBits <= 2'd0;
      tcBit   <= 1'b0;
    end else begin
      if (wrMode) begin
        enBit   <= wdata[MODE_EN];
        rlBit   <= wdata[MODE_RL];
        selBits <= wdata[MODE_SEL +: 2];
      end else if (hitPulse && !rlBit) begin
        enBit <= 1'b0;
      end
      if (hitPulse)
        tcBit <= 1'b1;
      else if (wrMode && wdata[MODE_TC])
        tcBit <= 1'b0;
    end
  end

  always_comb begin
    modeRd              = '0;
    modeRd[MODE_TC]     = tcBit;
    modeRd[MODE_EN]     = enBit;
    modeRd[MODE_RL]     = rlBit;
    modeRd[MODE_SEL +: 2] = selBits;
  end

  assign countRd  = count;
  assign reloadRd = reloadVal;

  assert_idle_count_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!enBit && !wrCount) |=> $stable(count));

  assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (rst)
    (hitPulse && !rlBit && !wrMode) |=> (!enBit && tcBit));

  assert_reload_continues_R6: assert property (@(posedge clk) disable iff (rst)
    (hitPulse && rlBit && !wrMode && !wrCount) |=> (enBit && count == $past(reloadVal)));

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int WDOG_TIMEOUT = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  tmr_strobe_t        strobe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [TMR_NUM-1:0] tmrIrq,
  output logic               wdogRst
);

  localparam int WD_W = $clog2(WDOG_TIMEOUT + 1);

  logic [DATA_W-1:0]  modeArr   [TMR_NUM];
  logic [CNT_W-1:0]   countArr  [TMR_NUM];
  logic [CNT_W-1:0]   reloadArr [TMR_NUM];
  logic [TMR_NUM-1:0] hitVec;
  logic [TMR_NUM-1:0] statusReg;
  logic               wdogArmed;
  logic [WD_W-1:0]    wdogCnt;

  for (genvar g = 0; g < TMR_NUM; g++) begin : gen_chan
    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wrMode   (strobe.wrMode[g]),
      .wrCount  (strobe.wrCount[g]),
      .wrReload (strobe.wrReload[g]),
      .wdata    (busWdata),
      .modeRd   (modeArr[g]),
      .countRd  (countArr[g]),
      .reloadRd (reloadArr[g]),
      .hitPulse (hitVec[g])
    );

    always_ff @(posedge clk) begin
      if (rst)
        statusReg[g] <= 1'b0;
      else if (hitVec[g])
        statusReg[g] <= 1'b1;
      else if (strobe.wrStatus && busWdata[g])
        statusReg[g] <= 1'b0;
    end

    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (statusReg[g] && !(strobe.wrStatus && busWdata[g])) |=> statusReg[g]);
  end

  assign tmrIrq = statusReg;

  // Watchdog: armed once, periodic one-clock reset pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      wdogArmed <= 1'b0;
      wdogCnt   <= '0;
      wdogRst   <= 1'b0;
    end else if (!wdogArmed) begin
      wdogRst <= 1'b0;
      if (strobe.wdogArm) begin
        wdogArmed <= 1'b1;
        wdogCnt   <= WD_W'(WDOG_TIMEOUT);
      end
    end else if (wdogCnt == WD_W'(1)) begin
      wdogRst <= 1'b1;
      wdogCnt <= WD_W'(WDOG_TIMEOUT);
    end else begin
      wdogRst <= 1'b0;
      wdogCnt <= wdogCnt - WD_W'(1);
    end
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < TMR_NUM; i++) begin
      if (busAddr == ADDR_W'(i * REG_PER_TMR))     busRdata = modeArr[i];
      if (busAddr == ADDR_W'(i * REG_PER_TMR + 1)) busRdata = DATA_W'(countArr[i]);
      if (busAddr == ADDR_W'(i * REG_PER_TMR + 2)) busRdata = DATA_W'(reloadArr[i]);
    end
    if (busAddr == ADDR_STATUS) busRdata = DATA_W'(statusReg);
    if (busAddr == ADDR_WDOG)   busRdata = DATA_W'(wdogArmed);
  end

  assert_wdog_stays_armed_R10: assert property (@(posedge clk) disable iff (rst)
    !$fell(wdogArmed));

  assert_rst_needs_arm_R9: assert property (@(posedge clk) disable iff (rst)
    wdogRst |-> wdogArmed);

  assert_rst_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    wdogRst |=> !wdogRst);

  assert_irq_follows_status_R7: assert property (@(posedge clk) disable iff (rst)
    hitVec != '0 |=> (tmrIrq & $past(hitVec)) == $past(hitVec));

endmodule

// File: rtl/dual_timer_wdog.sv
module dual_timer_wdog
  import tmr_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int WDOG_TIMEOUT = 256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      busWrEn,
  input  logic [tmr_pkg::ADDR_W-1:0]  busAddr,
  input  logic [tmr_pkg::DATA_W-1:0]  busWdata,
  output logic [tmr_pkg::DATA_W-1:0]  busRdata,
  output logic [tmr_pkg::TMR_NUM-1:0] tmrIrq,
  output logic                      wdogRst
);

  tmr_strobe_t strobe;

  tmr_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe)
  );

  tmr_datapath #(
    .CNT_W        (CNT_W),
    .WDOG_TIMEOUT (WDOG_TIMEOUT)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .tmrIrq   (tmrIrq),
    .wdogRst  (wdogRst)
  );

endmodule

// File: tb/test_dual_timer_wdog.sv
module test_dual_timer_wdog;
  localparam int WDT = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  tmrIrq;
  logic        wdogRst;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int          due;
    int          kind;   // 0 read data, 1 irq0, 2 irq1, 3 watchdog reset
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  dual_timer_wdog #(.CNT_W(32), .WDOG_TIMEOUT(WDT)) i_dual_timer_wdog (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tmrIrq(tmrIrq), .wdogRst(wdogRst)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every queued item whose due cycle is now
  always begin
    @(negedge clk);
    #2;
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].due == cyc) begin
        logic [31:0] act;
        case (sb[k].kind)
          0:       act = busRdata;
          1:       act = {31'b0, tmrIrq[0]};
          2:       act = {31'b0, tmrIrq[1]};
          default: act = {31'b0, wdogRst};
        endcase
        checks++;
        if (act !== sb[k].exp) begin
          fails++;
          $display("FAIL %s cycle %0d kind %0d: actual %h expected %h",
                   sb[k].tag, cyc, sb[k].kind, act, sb[k].exp);
        end
        sb.delete(k);
      end
    end
  end

  task automatic push(input int due, input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    busAddr = a;
    push(cyc, 0, e, tag);
    @(negedge clk);
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    push(cyc, 1, 0, "R1"); push(cyc, 2, 0, "R1"); push(cyc, 3, 0, "R1");
    for (int a = 0; a < 8; a++) expect_rd(3'(a), 32'h0, "R1");

    // R2: register map and mode field positions
    bus_write(3'd2, 32'h1234_5678);
    expect_rd(3'd2, 32'h1234_5678, "R2 reload0");
    bus_write(3'd3, 32'hFFFF_FF34);
    expect_rd(3'd3, 32'h0000_0034, "R2 mode1 fields");
    bus_write(3'd3, 32'h0);

    // R3 + R5: one-shot, divide by 1, count 5
    bus_write(3'd1, 32'd5);
    bus_write(3'd0, 32'h02);
    p = cyc;
    push(p + 4, 1, 0, "R3 irq0 early"); push(p + 5, 1, 1, "R5 irq0");
    wait_to(p + 2); expect_rd(3'd1, 32'd3, "R3 count");
    wait_to(p + 4); expect_rd(3'd6, 32'h0, "R3 status early");
    expect_rd(3'd6, 32'h1, "R5 status");
    expect_rd(3'd0, 32'h1, "R5 mode tc set en clear");
    repeat (4) @(negedge clk);
    expect_rd(3'd1, 32'd0, "R3 stopped holds");

    // R7: sticky status, write-1-to-clear, tc clear
    bus_write(3'd6, 32'h2);
    expect_rd(3'd6, 32'h1, "R7 write other bit no effect");
    bus_write(3'd6, 32'h0);
    expect_rd(3'd6, 32'h1, "R7 write zero no effect");
    bus_write(3'd6, 32'h1);
    push(cyc, 1, 0, "R7 irq0 cleared");
    expect_rd(3'd6, 32'h0, "R7 cleared");
    bus_write(3'd0, 32'h1);
    expect_rd(3'd0, 32'h0, "R7 tc cleared");

    // R4: timer1 divide by 8, count 3
    bus_write(3'd4, 32'd3);
    bus_write(3'd3, 32'h22);
    p = cyc;
    push(p + 23, 2, 0, "R4 irq1 early"); push(p + 24, 2, 1, "R4 irq1");
    wait_to(p + 8);  expect_rd(3'd4, 32'd2, "R4 div8 count");
    wait_to(p + 16); expect_rd(3'd4, 32'd1, "R4 div8 count");
    wait_to(p + 23); expect_rd(3'd6, 32'h0, "R4 status early");
    expect_rd(3'd6, 32'h2, "R7 timer1 is bit1");
    bus_write(3'd6, 32'h2);
    bus_write(3'd3, 32'h1);

    // R4: timer0 divide by 4 and by 16
    bus_write(3'd1, 32'd3);
    bus_write(3'd0, 32'h12);
    p = cyc;
    wait_to(p + 11); expect_rd(3'd6, 32'h0, "R4 div4 early");
    expect_rd(3'd6, 32'h1, "R4 div4 hit");
    bus_write(3'd6, 32'h1);
    bus_write(3'd1, 32'd2);
    bus_write(3'd0, 32'h33);
    p = cyc;
    wait_to(p + 31); expect_rd(3'd6, 32'h0, "R4 div16 early");
    expect_rd(3'd6, 32'h1, "R4 div16 hit");
    bus_write(3'd6, 32'h1);

    // R6: auto-reload, reload 3, count 2
    bus_write(3'd2, 32'd3);
    bus_write(3'd1, 32'd2);
    bus_write(3'd0, 32'h07);
    p = cyc;
    wait_to(p + 2); expect_rd(3'd6, 32'h1, "R6 first hit");
    bus_write(3'd6, 32'h1);
    expect_rd(3'd1, 32'd1, "R6 reloaded count running");
    expect_rd(3'd6, 32'h1, "R6 second hit");
    expect_rd(3'd0, 32'h7, "R6 still enabled");
    bus_write(3'd0, 32'h1);
    bus_write(3'd6, 32'h1);
    expect_rd(3'd6, 32'h0, "R6 cleanup");

    // R8: broken sequences do not arm
    bus_write(3'd7, 32'h1E1E_1E1E);
    bus_write(3'd7, 32'h0000_0000);
    bus_write(3'd7, 32'hE1E1_E1E1);
    expect_rd(3'd7, 32'h0, "R8 interrupted sequence");
    bus_write(3'd7, 32'hE1E1_E1E1);
    expect_rd(3'd7, 32'h0, "R8 second key alone");
    push(cyc + 5, 3, 0, "R8 no reset while unarmed");

    // R8/R9: correct sequence arms, periodic one-clock pulse
    bus_write(3'd7, 32'h1E1E_1E1E);
    bus_write(3'd7, 32'hE1E1_E1E1);
    p = cyc;
    push(p + WDT - 1, 3, 0, "R9 before pulse");
    push(p + WDT,     3, 1, "R9 pulse");
    push(p + WDT + 1, 3, 0, "R9 one cycle");
    push(p + 2 * WDT, 3, 1, "R9 periodic");
    expect_rd(3'd7, 32'h1, "R8 armed");

    // R10: writes cannot disarm
    bus_write(3'd7, 32'h0);
    bus_write(3'd7, 32'h1E1E_1E1E);
    bus_write(3'd7, 32'hFFFF_FFFF);
    expect_rd(3'd7, 32'h1, "R10 still armed");
    wait_to(p + 2 * WDT + 3);

    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc == 20000);
    fails++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule